// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the word address for one port of a synchronous RAM. In every clock cycle it selects the location the array accesses. It can take a fresh external address, step an internal counter forward, keep the counter where it is, or return to the address captured at the most recent external load. Three active-low strobes pick among these actions.

The chosen address goes straight to `addr_o` in the same cycle, so no dead cycle separates a load, a step or a return from the access it selects. The counter register then takes that address at the rising edge. A second register holds the last externally loaded address, which serves as the target of a return. `last_addr_o` shows that register. A host can start a burst at any address, walk through it, pause in place, and replay it from its start as many times as it needs. A read or write can proceed in the same cycle as any of these actions.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset (`rst_ni` low, asynchronous), the counter and the last-load register are zero. With all strobes high, `addr_o` and `last_addr_o` both read 0.
- R2: While `ld_ni` is low, `addr_o` equals `ext_addr_i` in the same cycle. The counter takes that value at the rising edge, and successive loads may carry unrelated addresses.
- R3: A rising edge with `ld_ni` low copies `ext_addr_i` into the last-load register, so `last_addr_o` shows it from the next cycle on.
- R4: With `ld_ni` high, `rpt_ni` high and `inc_ni` low, `addr_o` equals the previous cycle's `addr_o` plus one. The counter takes that value at the edge.
- R5: Stepping forward from the all-ones address gives zero. The address is `AW` bits wide, 18 by default.
- R6: With `ld_ni`, `rpt_ni` and `inc_ni` all high, `addr_o` equals the previous cycle's `addr_o`.
- R7: With `ld_ni` high and `rpt_ni` low, `addr_o` equals `last_addr_o` in the same cycle. The counter then continues from that address.
- R8: On any edge where `ld_ni` is high, `last_addr_o` keeps its value. Repeat and step cycles never alter it.
- R9: Priority is load over repeat over step over hold. Low `ld_ni` overrides the other two strobes, and low `rpt_ni` overrides `inc_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | AW | External address |
| ld_ni | input | 1 | Load strobe, active low |
| inc_ni | input | 1 | Step strobe, active low |
| rpt_ni | input | 1 | Return-to-last-load strobe, active low |
| addr_o | output | AW | Address presented to the array this cycle |
| last_addr_o | output | AW | Last externally loaded address |

## Verification
The bench drives load as the only strobe low, and also with the repeat and step strobes low beside it. A design with the priority reversed would output the counter or the last-load value instead of the external address. It steps through the all-ones address to check the wrap; a counter one bit too wide, or one that saturates, would not produce zero there. It repeats right after a long burst and after a hold. A design that registered the selection would show the old counter value for one cycle, and a design that let repeat or step write the last-load register would lose the start of the burst. Mixed random strobe patterns follow, each compared against a reference model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    SEL_LOAD = 2'd0,
    SEL_RPT  = 2'd1,
    SEL_INC  = 2'd2,
    SEL_HOLD = 2'd3
  } addr_sel_e;
endpackage

// File: rtl/burst_sel_dec.sv
module burst_sel_dec
  import burst_addr_pkg::*;
(
  input  logic      ld_ni,
  input  logic      inc_ni,
  input  logic      rpt_ni,
  output addr_sel_e sel_o
);
  // load > repeat > step > hold
  always_comb begin
    if (!ld_ni)       sel_o = SEL_LOAD;
    else if (!rpt_ni) sel_o = SEL_RPT;
    else if (!inc_ni) sel_o = SEL_INC;
    else              sel_o = SEL_HOLD;
  end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  addr_sel_e       sel_i,
  input  logic [AW-1:0]   ext_addr_i,
  input  logic [AW-1:0]   cnt_q_i,
  input  logic [AW-1:0]   last_q_i,
  output logic [AW-1:0]   nxt_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    unique case (sel_i)
      SEL_LOAD: nxt_o = ext_addr_i;
      SEL_RPT:  nxt_o = last_q_i;
      SEL_INC:  nxt_o = cnt_q_i + ONE;  // wraps modulo 2**AW
      default:  nxt_o = cnt_q_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int unsigned AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          ld_ni,
  input  logic          inc_ni,
  input  logic          rpt_ni,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] last_addr_o
);
  addr_sel_e     sel;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] nxt;

  burst_sel_dec u_dec (
    .ld_ni  (ld_ni),
    .inc_ni (inc_ni),
    .rpt_ni (rpt_ni),
    .sel_o  (sel)
  );

  burst_next_addr #(.AW(AW)) u_nxt (
    .sel_i      (sel),
    .ext_addr_i (ext_addr_i),
    .cnt_q_i    (cnt_q),
    .last_q_i   (last_q),
    .nxt_o      (nxt)
  );

  // counter always follows the address just accessed
  burst_addr_reg #(.AW(AW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .d_i    (nxt),
    .q_o    (cnt_q)
  );

  burst_addr_reg #(.AW(AW)) u_last (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sel == SEL_LOAD),
    .d_i    (ext_addr_i),
    .q_o    (last_q)
  );

  assign addr_o      = nxt;
  assign last_addr_o = last_q;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned AW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] ext_addr_i,
  input logic          ld_ni,
  input logic          inc_ni,
  input logic          rpt_ni,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] last_addr_o
);
  logic [AW-1:0] prev_addr;
  logic          prev_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
    end else begin
      prev_addr <= addr_o;
      prev_vld  <= 1'b1;
    end
  end

  a_r2_load_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ni |-> addr_o == ext_addr_i);

  a_r3_last_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ni |=> last_addr_o == $past(ext_addr_i));

  a_r4_step_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld && ld_ni && rpt_ni && !inc_ni) |-> addr_o == AW'(prev_addr + AW'(1)));

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld && ld_ni && rpt_ni && inc_ni) |-> addr_o == prev_addr);

  a_r7_repeat_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && !rpt_ni) |-> addr_o == last_addr_o);

  a_r8_last_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> $stable(last_addr_o));
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_addr_i  (ext_addr_i),
  .ld_ni       (ld_ni),
  .inc_ni      (inc_ni),
  .rpt_ni      (rpt_ni),
  .addr_o      (addr_o),
  .last_addr_o (last_addr_o)
);

// File: tb/burst_addr_ctr_tb_top.sv
`timescale 1ns/1ps
module burst_addr_ctr_tb_top;
  localparam int unsigned AW = 18;
  localparam logic [AW-1:0] ALL1 = '1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          ld_ni = 1'b1, inc_ni = 1'b1, rpt_ni = 1'b1;
  logic [AW-1:0] addr_o, last_addr_o;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] cnt_m = '0, last_m = '0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_ctr #(.AW(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_addr_i(ext_addr_i),
    .ld_ni(ld_ni), .inc_ni(inc_ni), .rpt_ni(rpt_ni),
    .addr_o(addr_o), .last_addr_o(last_addr_o)
  );

  function automatic logic [AW-1:0] model_addr(logic ld, logic inc, logic rpt,
                                               logic [AW-1:0] ext,
                                               logic [AW-1:0] cnt,
                                               logic [AW-1:0] last);
    if (!ld)       return ext;
    else if (!rpt) return last;
    else if (!inc) return cnt + AW'(1);
    else           return cnt;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check before posedge, update model at posedge
  task automatic step(logic ld, logic inc, logic rpt, logic [AW-1:0] ext, string req);
    logic [AW-1:0] exp;
    @(negedge clk_i);
    ld_ni = ld; inc_ni = inc; rpt_ni = rpt; ext_addr_i = ext;
    #1;
    exp = model_addr(ld, inc, rpt, ext, cnt_m, last_m);
    check(req, addr_o, exp);
    check(ld ? "R8" : "R3", last_addr_o, last_m);
    @(posedge clk_i);
    cnt_m = exp;
    if (!ld) last_m = ext;
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    #1;
    check("R1", addr_o, '0);
    check("R1", last_addr_o, '0);
    rst_ni = 1'b1;
    step(1, 1, 1, 18'h1234, "R1");            // hold after reset reads 0
    step(0, 1, 1, 18'h00100, "R2");
    step(1, 0, 1, 18'h3ffff, "R4");
    step(1, 0, 1, 18'h00000, "R4");
    step(1, 1, 1, 18'h2aaaa, "R6");
    step(1, 0, 1, 18'h0, "R4");
    step(1, 1, 0, 18'h0, "R7");                // back to 0x100, same cycle
    step(1, 0, 1, 18'h0, "R4");
    step(0, 1, 1, 18'h0fff0, "R2");            // non-sequential load
    step(0, 1, 1, 18'h00007, "R2");
    step(0, 0, 0, ALL1 - AW'(1), "R9");        // load wins over repeat/step
    step(1, 0, 0, 18'h0, "R9");                // repeat wins over step
    step(1, 0, 1, 18'h0, "R4");
    step(1, 0, 1, 18'h0, "R5");                // all-ones -> 0
    step(1, 0, 1, 18'h0, "R5");
    step(1, 1, 0, 18'h0, "R7");
    step(1, 1, 0, 18'h0, "R7");
    step(0, 1, 1, ALL1, "R2");
    step(1, 0, 1, 18'h0, "R5");
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      logic ld, inc, rpt;
      r   = AW'($urandom);
      ld  = (k < 2) ? 1'b0 : 1'b1;
      rpt = (k == 2 || k == 9 && r[0]) ? 1'b0 : 1'b1;
      inc = (k >= 3 && k <= 7 || r[1]) ? 1'b0 : 1'b1;
      if (r[7:4] == 4'hf) r = ALL1;
      step(ld, inc, rpt, r, !ld ? "R2" : !rpt ? "R7" : !inc ? "R4" : "R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule